// File: doc/BRIEF.md
# Zero-Cross Gated Update Controller

This block decides when a freshly received control word of an audio volume and tone processor takes effect. A receiver raises a one-cycle load strobe when chip enable falls, and presents two groups of control bits with it: a two-bit mode field and a four-bit detection-point code. Both groups take effect at once on the load. In zero-cross mode the block holds the word pending. It commits the word on the first rising zero-cross pulse from the chosen detection point, so that gain switches change near a signal null.

If no zero crossing arrives, for example with a silent or very low-frequency signal, a no-signal timeout forces the commit. That timeout is a count of ticks from an external slow tick source, a few tens of milliseconds in a typical system. Any other mode commits the word in the cycle after the load. The analogue comparators and the slow tick source lie outside the block. The four zero-cross inputs are asynchronous.

Top module: `zc_update_ctrl`

## Requirements
- R1: A load with mode bits `00` enters the waiting state and does not commit on its own; commitStrobe stays low until a selected zero cross or the timeout.
- R2: A load with mode bits `01`, `10` or `11` produces commitStrobe high in the cycle right after the load cycle, with no zero cross or tick needed.
- R3: The point code is decoded with bit 0 as the first received bit: `0000` gives detectSel 0 (selector), `0001` gives 1 (volume), `0010` gives 2 (tone), `0011` gives 3 (fader), and any code with bit 2 or bit 3 set gives 0.
- R4: detectSel takes its new value in the cycle after every load, in any mode, and does not change between loads.
- R5: While waiting, a rising edge on the selected zcIn line commits the word. commitStrobe is high on the third clock edge after the input rises (two synchronizer stages, then one edge stage). Rising edges on the other three lines have no effect.
- R6: While waiting, the TIMEOUT_TICKS-th timerTick after the load commits the word in the cycle after that tick. Fewer ticks do not commit. Ticks when nothing is pending do nothing.
- R7: A load that arrives while a word is pending replaces it and restarts the timeout count from zero. Only the newest word is committed, and only once.
- R8: commitStrobe is a single-cycle pulse, and each word gives at most one commit. Zero crosses or ticks after a commit give no further commit until the next load.
- R9: A zcIn line is edge-sensitive. A line held high produces one edge only, and a new load does not count a line that is already high as a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadStrobe | input | 1 | One-cycle pulse: new word received (chip enable fell) |
| zcModeBits | input | 2 | Update mode; `00` waits for a zero cross, other values commit at once |
| pointBits | input | 4 | Detection-point code, bit 0 received first |
| zcIn | input | 4 | Asynchronous zero-cross pulses: selector, volume, tone, fader |
| timerTick | input | 1 | One-cycle tick of the no-signal timeout time base |
| commitStrobe | output | 1 | One-cycle pulse: apply the pending word to the active registers |
| detectSel | output | 2 | Index of the detection point in use |

## Verification
The bench sweeps every mode with every point code. In the waiting mode it fires each of the four zero-cross lines in turn. A design that swapped the decode bit order, or honoured an unselected line, would commit early or on the wrong line, and the exact third-edge latency check catches an extra or missing synchronizer stage. The timeout is checked one tick short and at the exact tick, which finds off-by-one counters. A replacement load part way through a count exposes a timer that does not restart. A line held high across a new load exposes level detection. A superseded word committed on its own, or a second commit after the first, shows up in the commit count.

// File: rtl/zcu_pkg.sv
package zcu_pkg;

  localparam int NUM_POINTS = 4;
  localparam int SEL_W      = $clog2(NUM_POINTS);
  localparam int CODE_W     = 4;
  localparam int MODE_W     = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } zcuState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchPoint;
    logic restartTimer;
    logic countEnable;
  } zcuStrobes_t;

  // Detection-point code: bit 0 is the first bit received
  function automatic logic [SEL_W-1:0] decodePoint(input logic [CODE_W-1:0] code);
    logic [SEL_W-1:0] sel;
    unique case (code)
      4'b0001: sel = 2'd1;
      4'b0010: sel = 2'd2;
      4'b0011: sel = 2'd3;
      default: sel = 2'd0;
    endcase
    return sel;
  endfunction

  function automatic logic waitsForCrossing(input logic [MODE_W-1:0] mode);
    return (mode == 2'b00);
  endfunction

endpackage

// File: rtl/zcu_datapath.sv
module zcu_datapath
  import zcu_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  zcuStrobes_t           strobes,
  input  logic [CODE_W-1:0]     pointBits,
  input  logic [NUM_POINTS-1:0] zcIn,
  input  logic                  timerTick,
  output logic                  selEdge,
  output logic                  timeoutHit,
  output logic [SEL_W-1:0]      detectSel
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic [NUM_POINTS-1:0] edgeVec;
  logic [SEL_W-1:0]      selReg;
  logic [CNT_W-1:0]      tickCount;

  // Per-line synchronizer followed by a rising-edge detector
  for (genvar i = 0; i < NUM_POINTS; i++) begin : g_line
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   prevLevel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncChain <= '0;
        prevLevel <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], zcIn[i]};
        prevLevel <= syncChain[SYNC_STAGES-1];
      end
    end

    assign edgeVec[i] = syncChain[SYNC_STAGES-1] & ~prevLevel;
  end

  // Detection point is taken from every load, whatever the mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg <= '0;
    end else if (strobes.latchPoint) begin
      selReg <= decodePoint(pointBits);
    end
  end

  // No-signal timeout counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCount <= '0;
    end else if (strobes.restartTimer) begin
      tickCount <= '0;
    end else if (strobes.countEnable && timerTick && (tickCount != LAST_COUNT)) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  assign timeoutHit = strobes.countEnable && timerTick && (tickCount == LAST_COUNT);
  assign selEdge    = edgeVec[selReg];
  assign detectSel  = selReg;

endmodule

// File: rtl/zcu_control.sv
module zcu_control
  import zcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStrobe,
  input  logic [MODE_W-1:0] zcModeBits,
  input  logic              selEdge,
  input  logic              timeoutHit,
  output zcuStrobes_t       strobes,
  output logic              commitStrobe
);

  zcuState_t state;

  always_comb begin
    strobes.latchPoint   = loadStrobe;
    strobes.restartTimer = loadStrobe;
    strobes.countEnable  = (state == ST_WAIT) && !loadStrobe;
  end

  // A load wins over a crossing or timeout in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      commitStrobe <= 1'b0;
    end else if (loadStrobe) begin
      if (waitsForCrossing(zcModeBits)) begin
        state        <= ST_WAIT;
        commitStrobe <= 1'b0;
      end else begin
        state        <= ST_IDLE;
        commitStrobe <= 1'b1;
      end
    end else if ((state == ST_WAIT) && (selEdge || timeoutHit)) begin
      state        <= ST_IDLE;
      commitStrobe <= 1'b1;
    end else begin
      commitStrobe <= 1'b0;
    end
  end

endmodule

// File: rtl/zc_update_ctrl.sv
module zc_update_ctrl
  import zcu_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadStrobe,
  input  logic [1:0] zcModeBits,
  input  logic [3:0] pointBits,
  input  logic [3:0] zcIn,
  input  logic       timerTick,
  output logic       commitStrobe,
  output logic [1:0] detectSel
);

  zcuStrobes_t strobes;
  logic        selEdge;
  logic        timeoutHit;

  zcu_control u_control (
    .clk          (clk),
    .rst_n        (rst_n),
    .loadStrobe   (loadStrobe),
    .zcModeBits   (zcModeBits),
    .selEdge      (selEdge),
    .timeoutHit   (timeoutHit),
    .strobes      (strobes),
    .commitStrobe (commitStrobe)
  );

  zcu_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .pointBits  (pointBits),
    .zcIn       (zcIn),
    .timerTick  (timerTick),
    .selEdge    (selEdge),
    .timeoutHit (timeoutHit),
    .detectSel  (detectSel)
  );

endmodule

// File: rtl/zcu_checker.sv
module zcu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       loadStrobe,
  input logic [1:0] zcModeBits,
  input logic [3:0] pointBits,
  input logic       commitStrobe,
  input logic [1:0] detectSel
);

  AST_WAIT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStrobe && zcModeBits == 2'b00) |=> !commitStrobe); // R1

  AST_IMMEDIATE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStrobe && zcModeBits != 2'b00) |=> commitStrobe); // R2

  AST_POINT_FADER: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStrobe && pointBits == 4'b0011) |=> (detectSel == 2'd3)); // R3

  AST_POINT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStrobe && (pointBits[3] || pointBits[2])) |=> (detectSel == 2'd0)); // R3

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !loadStrobe |=> $stable(detectSel)); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (commitStrobe && !loadStrobe) |=> !commitStrobe); // R8

endmodule

bind zc_update_ctrl zcu_checker u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .loadStrobe   (loadStrobe),
  .zcModeBits   (zcModeBits),
  .pointBits    (pointBits),
  .commitStrobe (commitStrobe),
  .detectSel    (detectSel)
);

// File: tb/zc_update_ctrl_bench.sv
module zc_update_ctrl_bench;

  localparam int TICKS = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [1:0] zcModeBits = 2'b00;
  logic [3:0] pointBits = 4'b0000;
  logic [3:0] zcIn = 4'b0000;
  logic       timerTick = 1'b0;
  logic       commitStrobe;
  logic [1:0] detectSel;

  int checks = 0;
  int errors = 0;
  int commits = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zc_update_ctrl #(.SYNC_STAGES(2), .TIMEOUT_TICKS(TICKS)) u_zc_update_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .loadStrobe   (loadStrobe),
    .zcModeBits   (zcModeBits),
    .pointBits    (pointBits),
    .zcIn         (zcIn),
    .timerTick    (timerTick),
    .commitStrobe (commitStrobe),
    .detectSel    (detectSel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All waiting goes through here: one cycle, sampled at the falling edge
  task automatic step();
    @(negedge clk);
    if (commitStrobe) commits++;
  endtask

  task automatic doLoad(input logic [1:0] mode, input logic [3:0] code);
    loadStrobe = 1'b1;
    zcModeBits = mode;
    pointBits  = code;
    step();
    loadStrobe = 1'b0;
  endtask

  task automatic tick();
    timerTick = 1'b1;
    step();
    timerTick = 1'b0;
  endtask

  // Raise one line, drop it after three cycles; report first commit offset
  task automatic fireZc(input int k, output int lat);
    lat = -1;
    zcIn[k] = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      step();
      if (commitStrobe && lat < 0) lat = i;
      if (i == 3) zcIn[k] = 1'b0;
    end
  endtask

  initial begin
    int lat;
    int base;
    int expSel;
    repeat (3) step();
    check(commitStrobe == 1'b0, "R8 reset commit", int'(commitStrobe), 0);
    check(detectSel == 2'd0, "R4 reset detectSel", int'(detectSel), 0);
    rst_n = 1'b1;
    step();

    // R2 and R3: immediate modes, every point code
    for (int m = 1; m < 4; m++) begin
      for (int c = 0; c < 16; c++) begin
        expSel = (c < 4) ? c : 0;
        base = commits;
        doLoad(2'(m), 4'(c));
        check(commitStrobe == 1'b1, "R2 immediate commit", int'(commitStrobe), 1);
        check(int'(detectSel) == expSel, "R3 decode", int'(detectSel), expSel);
        step();
        check(commitStrobe == 1'b0, "R8 single pulse", int'(commitStrobe), 0);
        check(commits - base == 1, "R2 one commit", commits - base, 1);
      end
    end

    // R1, R3, R5: waiting mode, every code, every line
    for (int c = 0; c < 16; c++) begin
      expSel = (c < 4) ? c : 0;
      base = commits;
      doLoad(2'b00, 4'(c));
      check(commitStrobe == 1'b0, "R1 no commit on load", int'(commitStrobe), 0);
      check(int'(detectSel) == expSel, "R3 decode wait", int'(detectSel), expSel);
      for (int k = 0; k < 4; k++) begin
        if (k != expSel) begin
          fireZc(k, lat);
          check(commits == base, "R5 unselected ignored", commits - base, 0);
        end
      end
      fireZc(expSel, lat);
      check(lat == 3, "R5 latency", lat, 3);
      check(commits - base == 1, "R5 one commit", commits - base, 1);
      check(int'(detectSel) == expSel, "R4 held", int'(detectSel), expSel);
      // R8: further crossings and ticks after the commit
      fireZc(expSel, lat);
      for (int t = 0; t < TICKS + 1; t++) tick();
      check(commits - base == 1, "R8 no second commit", commits - base, 1);
    end

    // R6: timeout exact count, and ticks when idle
    base = commits;
    for (int t = 0; t < TICKS + 2; t++) tick();
    check(commits == base, "R6 idle ticks ignored", commits - base, 0);
    doLoad(2'b00, 4'b0010);
    for (int t = 0; t < TICKS - 1; t++) tick();
    check(commits == base, "R6 not before timeout", commits - base, 0);
    tick();
    check(commitStrobe == 1'b1, "R6 timeout commit", int'(commitStrobe), 1);
    step();
    check(commits - base == 1, "R6 one commit", commits - base, 1);

    // R7: replacement restarts the timer
    base = commits;
    doLoad(2'b00, 4'b0001);
    for (int t = 0; t < 3; t++) tick();
    doLoad(2'b00, 4'b0011);
    check(detectSel == 2'd3, "R7 new point", int'(detectSel), 3);
    for (int t = 0; t < TICKS - 1; t++) tick();
    check(commits == base, "R7 timer restarted", commits - base, 0);
    tick();
    check(commits - base == 1, "R7 single commit", commits - base, 1);

    // R7: pending word replaced by an immediate one
    base = commits;
    doLoad(2'b00, 4'b0000);
    step();
    doLoad(2'b11, 4'b0000);
    for (int t = 0; t < TICKS + 2; t++) tick();
    fireZc(0, lat);
    check(commits - base == 1, "R7 replaced by immediate", commits - base, 1);

    // R9: level held high gives one edge; reload does not see the level
    base = commits;
    doLoad(2'b00, 4'b0000);
    zcIn[0] = 1'b1;
    for (int i = 0; i < 6; i++) step();
    check(commits - base == 1, "R9 held level one commit", commits - base, 1);
    doLoad(2'b00, 4'b0000);
    for (int i = 0; i < 6; i++) step();
    check(commits - base == 1, "R9 level not a crossing", commits - base, 1);
    zcIn[0] = 1'b0;
    step();
    step();
    fireZc(0, lat);
    check(lat == 3, "R9 new rise commits", lat, 3);
    check(commits - base == 2, "R9 total", commits - base, 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule